// File: doc/BRIEF.md
# Posted-write register synchronizer

This block is the bus-side register front end of a peripheral whose functional logic runs on a second clock. That clock is unrelated to the bus clock and may be much slower. A set of synchronized registers (control, counter, load, trigger, match) is written from the bus. Each write is moved into the functional clock domain by its own toggle handshake. The functional-domain copies are presented on a flat output vector, which stands in for the timer logic.

In posted mode, a write completes on the bus at once. A per-register pending bit shows that the transfer is still crossing. A second write to a busy register is dropped and flagged. In blocking mode, the bus ready line is held low until the crossing has finished, so no write is lost.

A few direct registers (identification, system status, interface control, pending word) are accessed without any crossing. Writing the interface-control register with its reset bit set starts a soft reset. The soft reset restores the functional copies and the bus shadows to their defaults and re-enables posted mode. A reset-done flag in the system-status register reads low until the functional domain has held its reset for a fixed number of its own cycles.

Top module: `pws_bridge`

## Requirements
- R1: After hard reset:
  - the pending word reads 0;
  - system-status bit 0 (reset done) reads 1;
  - interface-control reads 0x4 (bit 2 = posted mode on);
  - every functional output is 0;
  - the identification register reads the ID_VALUE parameter (default 0x51570001).
- R2: Address map, using byte offsets, 32-bit registers and the low 8 address bits:
  - 0x00 identification;
  - 0x04 system status;
  - 0x08 interface control;
  - 0x0C pending word;
  - synchronized register i at 0x10 + 4*i, where i = 0 control, 1 counter, 2 load, 3 trigger, 4 match.
  - Reading synchronized register i returns the value most recently accepted for it.
- R3: A posted write to synchronized register i completes in its first cycle with err low. It sets pending bit i, which is visible on the next transfer. The value then appears on f_regs[32*i +: 32], and pending bit i clears afterwards.
- R4: In posted mode, a write to a synchronized register whose pending bit is set is dropped and completes with err high. The functional output keeps the first value.
- R5: In posted mode, a read of a synchronized register whose pending bit is set completes at once with err high. It returns the accepted value.
- R6: With interface-control bit 2 cleared (blocking mode), a write to a synchronized register holds ready low until its handshake has completed.
  - The write then completes with err low.
  - Once it completes, the pending word is 0 and the functional output holds the value.
  - A read of a register still pending from an earlier posted write stalls the same way and completes with err low.
- R7: Writing interface-control with bit 1 set (for example 0x06) starts a soft reset.
  - System-status bit 0 reads 0 on the next transfer.
  - Bit 0 returns to 1 only after the functional domain has held reset for RST_HOLD functional cycles.
  - Afterwards, functional outputs and register shadows are 0, the pending word is 0, and interface-control reads 0x4.
- R8: While a soft reset is in progress:
  - writes to synchronized registers are dropped with err high;
  - writes to interface-control are ignored.
- R9: Reads of unmapped offsets return 0 with err low. Writes to the identification, system-status and pending registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus-domain hard reset, active low |
| sel | input | 1 | Transfer request, held until ready |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Byte offset of the register |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, valid while ready is high |
| ready | output | 1 | Transfer completes on this cycle |
| err | output | 1 | Transfer dropped or read of in-flight data |
| f_clk | input | 1 | Functional clock |
| f_rst_n | input | 1 | Functional-domain hard reset, active low |
| f_regs | output | NSYNC*DW | Functional-domain copies of the synchronized registers |

## Verification
The hardest state to reach from the ports is a blocking-mode access that meets a register whose handshake is already in flight. Blocking writes drain before they complete, so this state never arises in blocking mode alone. The stimulus reaches it by posting a write, switching to blocking mode through the direct interface-control register in the very next transfer, and then reading the register while the slow functional clock is still returning the acknowledge. The second hard case is the soft-reset window. It is reached by issuing accesses in the transfers right after the reset request, while the reset-done flag is still low.

// File: rtl/pws_pkg.sv
package pws_pkg;
  localparam logic [7:0] OFS_ID    = 8'h00;
  localparam logic [7:0] OFS_STAT  = 8'h04;
  localparam logic [7:0] OFS_IFC   = 8'h08;
  localparam logic [7:0] OFS_PEND  = 8'h0C;
  localparam logic [7:0] OFS_SYNC0 = 8'h10;
  localparam int IFC_SRST_BIT   = 1;
  localparam int IFC_POSTED_BIT = 2;

  // Address of synchronized register slot k.
  function automatic logic [7:0] sync_addr(input int unsigned k);
    return 8'(32'(OFS_SYNC0) + 4 * k);
  endfunction

  // True when a hits one of the n synchronized register slots.
  function automatic logic sync_hit(input logic [7:0] a, input int unsigned n);
    return (a >= OFS_SYNC0) && (32'(a) < 32'(OFS_SYNC0) + 4 * n) && (a[1:0] == 2'b00);
  endfunction
endpackage

// File: rtl/pws_sync2.sv
module pws_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pws_lane.sv
module pws_lane #(
  parameter int DW = 32,
  parameter logic [DW-1:0] DEF = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          clr,
  input  logic [DW-1:0] wdata,
  output logic          pend,
  output logic [DW-1:0] shadow,
  input  logic          f_clk,
  input  logic          f_rst_n,
  input  logic          f_busy,
  output logic [DW-1:0] f_q
);
  logic          req_t;
  logic          ack_s;
  logic [DW-1:0] hold;
  logic          req_s;
  logic          f_ack;
  logic          f_load;

  // bus side: toggle request, hold data stable until acknowledged
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_t <= 1'b0;
      hold  <= DEF;
    end else if (launch) begin
      req_t <= ~req_t;
      hold  <= wdata;
    end else if (clr) begin
      hold  <= DEF;
    end
  end

  pws_sync2 u_ack_sync (.clk(clk), .rst_n(rst_n), .d(f_ack), .q(ack_s));

  assign pend   = req_t ^ ack_s;
  assign shadow = hold;

  // functional side: capture on request edge, return the toggle
  pws_sync2 u_req_sync (.clk(f_clk), .rst_n(f_rst_n), .d(req_t), .q(req_s));

  assign f_load = req_s ^ f_ack;

  always_ff @(posedge f_clk or negedge f_rst_n) begin
    if (!f_rst_n) begin
      f_ack <= 1'b0;
      f_q   <= DEF;
    end else begin
      if (f_load) f_ack <= req_s;
      if (f_busy) f_q <= DEF;
      else if (f_load) f_q <= hold;
    end
  end

  // R4
  launch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !pend);

  // R3
  fq_hold_chk: assert property (@(posedge f_clk) disable iff (!f_rst_n)
    (!f_load && !f_busy) |=> $stable(f_q));
endmodule

// File: rtl/pws_srst.sv
module pws_srst #(
  parameter int RST_HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  input  logic f_clk,
  input  logic f_rst_n,
  output logic f_busy
);
  localparam int CW = (RST_HOLD > 1) ? $clog2(RST_HOLD) : 1;

  logic          tgl;
  logic          ack_s;
  logic          req_s;
  logic          f_seen;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgl <= 1'b0;
    else if (start) tgl <= ~tgl;
  end

  pws_sync2 u_ack_sync (.clk(clk), .rst_n(rst_n), .d(f_seen), .q(ack_s));
  assign busy = tgl ^ ack_s;

  pws_sync2 u_req_sync (.clk(f_clk), .rst_n(f_rst_n), .d(tgl), .q(req_s));
  assign f_busy = req_s ^ f_seen;

  // hold the functional reset for RST_HOLD cycles, then acknowledge
  always_ff @(posedge f_clk or negedge f_rst_n) begin
    if (!f_rst_n) begin
      f_seen <= 1'b0;
      cnt    <= '0;
    end else if (f_busy) begin
      if (cnt == CW'(RST_HOLD - 1)) begin
        f_seen <= req_s;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R7
  srst_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  // R8
  srst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/pws_bridge.sv
module pws_bridge
  import pws_pkg::*;
#(
  parameter int          NSYNC    = 5,
  parameter int          DW       = 32,
  parameter int          RST_HOLD = 4,
  parameter logic [31:0] ID_VALUE = 32'h5157_0001
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel,
  input  logic                wr,
  input  logic [7:0]          addr,
  input  logic [DW-1:0]       wdata,
  output logic [DW-1:0]       rdata,
  output logic                ready,
  output logic                err,
  input  logic                f_clk,
  input  logic                f_rst_n,
  output logic [NSYNC*DW-1:0] f_regs
);
  localparam int IW = (NSYNC > 1) ? $clog2(NSYNC) : 1;

  function automatic logic [IW-1:0] slot_of(input logic [7:0] a);
    return IW'((a - OFS_SYNC0) >> 2);
  endfunction

  logic [NSYNC-1:0] pend;
  logic [NSYNC-1:0] launch_v;
  logic [DW-1:0]    shadow [NSYNC];
  logic             posted;
  logic             blk_go;
  logic             rst_busy;
  logic             f_busy;
  logic             srst_start;
  logic             hit;
  logic [IW-1:0]    idx;
  logic             pi;
  logic             ifc_wr;

  assign hit = sync_hit(addr, NSYNC);
  assign idx = hit ? slot_of(addr) : '0;
  assign pi  = hit && pend[idx];
  assign ifc_wr = sel && wr && (addr == OFS_IFC) && !rst_busy;

  always_comb begin
    launch_v   = '0;
    ready      = 1'b1;
    err        = 1'b0;
    rdata      = '0;
    srst_start = 1'b0;
    if (sel) begin
      if (wr) begin
        if (hit) begin
          if (rst_busy) begin
            err = 1'b1;
          end else if (posted) begin
            if (pi) err = 1'b1;
            else launch_v[idx] = 1'b1;
          end else if (!blk_go) begin
            ready = 1'b0;
            if (!pi) launch_v[idx] = 1'b1;
          end else begin
            ready = !pi;
          end
        end else if (ifc_wr) begin
          srst_start = wdata[IFC_SRST_BIT];
        end
      end else begin
        if (hit) begin
          rdata = shadow[idx];
          if (pi) begin
            if (posted) err = 1'b1;
            else ready = 1'b0;
          end
        end else begin
          case (addr)
            OFS_ID:   rdata = DW'(ID_VALUE);
            OFS_STAT: rdata = DW'(!rst_busy);
            OFS_IFC:  rdata = DW'({posted, 2'b00});
            OFS_PEND: rdata = rst_busy ? '0 : DW'(pend);
            default:  rdata = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      posted <= 1'b1;
      blk_go <= 1'b0;
    end else begin
      if (srst_start) posted <= 1'b1;
      else if (ifc_wr) posted <= wdata[IFC_POSTED_BIT];
      if ((|launch_v) && !posted) blk_go <= 1'b1;
      else if (sel && ready) blk_go <= 1'b0;
    end
  end

  pws_srst #(.RST_HOLD(RST_HOLD)) u_srst (
    .clk(clk), .rst_n(rst_n), .start(srst_start), .busy(rst_busy),
    .f_clk(f_clk), .f_rst_n(f_rst_n), .f_busy(f_busy)
  );

  for (genvar g = 0; g < NSYNC; g++) begin : g_lane
    logic [DW-1:0] fq;
    pws_lane #(.DW(DW), .DEF('0)) u_lane (
      .clk(clk), .rst_n(rst_n), .launch(launch_v[g]), .clr(srst_start),
      .wdata(wdata), .pend(pend[g]), .shadow(shadow[g]),
      .f_clk(f_clk), .f_rst_n(f_rst_n), .f_busy(f_busy), .f_q(fq)
    );
    assign f_regs[g*DW +: DW] = fq;
  end

  // R6
  stall_blocking_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !ready) |-> !posted);

  // R7
  posted_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_busy) |-> posted);

  // R8
  no_launch_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_busy |-> (launch_v == '0));
endmodule

// File: tb/test_pws_bridge.sv
`timescale 1ns/1ps
module test_pws_bridge;
  localparam int NS = 5;
  localparam int DW = 32;

  logic clk = 0, f_clk = 0, rst_n = 0, f_rst_n = 0;
  logic sel = 0, wr = 0;
  logic [7:0] addr = 0;
  logic [DW-1:0] wdata = 0;
  logic [DW-1:0] rdata;
  logic ready, err;
  logic [NS*DW-1:0] f_regs;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;
  always #18.5 f_clk = ~f_clk;

  pws_bridge i_pws_bridge (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ready(ready), .err(err), .f_clk(f_clk), .f_rst_n(f_rst_n),
    .f_regs(f_regs)
  );

  task automatic chk(input string req, input logic ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic w, input logic [7:0] a, input logic [31:0] d,
                      output logic [31:0] rd, output logic e, output int cyc);
    @(negedge clk);
    sel = 1; wr = w; addr = a; wdata = d; cyc = 0;
    forever begin
      #1;
      cyc++;
      if (ready) begin
        rd = rdata; e = err;
        break;
      end
      @(negedge clk);
    end
    @(posedge clk);
    #1 sel = 0; wr = 0;
  endtask

  function automatic logic [7:0] sa(input int k);
    return 8'(16 + 4 * k);
  endfunction

  function automatic logic [31:0] pat(input int k, input int s);
    return 32'h3C00_0000 + 32'(k) * 32'h0101_0101 + 32'(s) * 32'h0010_0000;
  endfunction

  task automatic wait_idle(output int polls);
    logic [31:0] rd; logic e; int c;
    polls = 0;
    do begin
      xfer(0, 8'h0C, 0, rd, e, c);
      polls++;
    end while (rd != 0 && polls < 500);
  endtask

  task automatic wait_done(output int polls);
    logic [31:0] rd; logic e; int c;
    polls = 0;
    do begin
      xfer(0, 8'h04, 0, rd, e, c);
      polls++;
    end while (rd[0] != 1'b1 && polls < 500);
  endtask

  initial begin : watchdog
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] rd; logic e; int c; int p;
    repeat (4) @(posedge clk);
    rst_n = 1; f_rst_n = 1;
    repeat (3) @(posedge clk);

    // R1 reset state
    xfer(0, 8'h0C, 0, rd, e, c); chk("R1 pending", rd == 0, rd, 0);
    xfer(0, 8'h04, 0, rd, e, c); chk("R1 sysstat", rd == 1, rd, 1);
    xfer(0, 8'h08, 0, rd, e, c); chk("R1 ifctrl", rd == 4, rd, 4);
    xfer(0, 8'h00, 0, rd, e, c); chk("R1 id", rd == 32'h5157_0001, rd, 32'h5157_0001);
    chk("R1 f_regs", f_regs == 0, f_regs[31:0], 0);

    // R3 / R2 posted sweep
    for (int k = 0; k < NS; k++) begin
      xfer(1, sa(k), pat(k, 0), rd, e, c);
      chk("R3 posted one cycle", c == 1 && e == 0, c, 1);
      xfer(0, 8'h0C, 0, rd, e, c);
      chk("R3 pending bit", rd == (32'd1 << k), rd, 32'd1 << k);
      wait_idle(p);
      chk("R3 pending clears", p < 500, p, 0);
      chk("R3 f value", f_regs[k*DW +: DW] == pat(k, 0), f_regs[k*DW +: DW], pat(k, 0));
      xfer(0, sa(k), 0, rd, e, c);
      chk("R2 readback", rd == pat(k, 0) && e == 0, rd, pat(k, 0));
    end

    // R3 all in flight together
    for (int k = 0; k < NS; k++) xfer(1, sa(k), pat(k, 1), rd, e, c);
    xfer(0, 8'h0C, 0, rd, e, c);
    chk("R3 all pending", rd == 32'h1F, rd, 32'h1F);

    // R5 read of pending register in posted mode
    xfer(0, sa(4), 0, rd, e, c);
    chk("R5 err on pending read", e == 1 && c == 1, {31'd0, e}, 1);
    chk("R5 accepted value", rd == pat(4, 1), rd, pat(4, 1));
    wait_idle(p);

    // R4 back-to-back write to same register
    for (int k = 0; k < NS; k++) begin
      xfer(1, sa(k), pat(k, 2), rd, e, c);
      xfer(1, sa(k), pat(k, 3), rd, e, c);
      chk("R4 second write err", e == 1, {31'd0, e}, 1);
      wait_idle(p);
      chk("R4 first value kept", f_regs[k*DW +: DW] == pat(k, 2), f_regs[k*DW +: DW], pat(k, 2));
    end

    // R6 blocking mode writes
    xfer(1, 8'h08, 0, rd, e, c);
    xfer(0, 8'h08, 0, rd, e, c); chk("R6 ifctrl cleared", rd == 0, rd, 0);
    for (int k = 0; k < NS; k++) begin
      xfer(1, sa(k), pat(k, 4), rd, e, c);
      chk("R6 write stalls", c > 2 && e == 0, c, 3);
      xfer(0, 8'h0C, 0, rd, e, c);
      chk("R6 pending zero", rd == 0, rd, 0);
      chk("R6 f value", f_regs[k*DW +: DW] == pat(k, 4), f_regs[k*DW +: DW], pat(k, 4));
    end

    // R6 blocking read of register left in flight by a posted write
    xfer(1, 8'h08, 32'h4, rd, e, c);
    xfer(1, sa(2), pat(2, 5), rd, e, c);
    xfer(1, 8'h08, 0, rd, e, c);
    xfer(0, sa(2), 0, rd, e, c);
    chk("R6 read stalls", c > 2 && e == 0, c, 3);
    chk("R6 read value", rd == pat(2, 5), rd, pat(2, 5));
    chk("R6 f after read", f_regs[2*DW +: DW] == pat(2, 5), f_regs[2*DW +: DW], pat(2, 5));

    // R7 soft reset (from blocking mode)
    xfer(1, 8'h08, 32'h6, rd, e, c);
    xfer(0, 8'h04, 0, rd, e, c); chk("R7 done low", rd == 0, rd, 0);
    // R8 accesses during reset
    xfer(1, sa(1), 32'hDEAD_BEEF, rd, e, c); chk("R8 write dropped", e == 1, {31'd0, e}, 1);
    xfer(1, 8'h08, 0, rd, e, c);
    wait_done(p);
    chk("R7 done returns", p > 1 && p < 500, p, 2);
    chk("R7 f_regs default", f_regs == 0, f_regs[63:32], 0);
    xfer(0, 8'h0C, 0, rd, e, c); chk("R7 pending zero", rd == 0, rd, 0);
    xfer(0, 8'h08, 0, rd, e, c); chk("R8 ifctrl write ignored", rd == 4, rd, 4);
    for (int k = 0; k < NS; k++) begin
      xfer(0, sa(k), 0, rd, e, c); chk("R7 shadow default", rd == 0, rd, 0);
    end
    xfer(1, sa(3), pat(3, 6), rd, e, c);
    chk("R7 posted after reset", c == 1 && e == 0, c, 1);
    wait_idle(p);
    chk("R7 write after reset", f_regs[3*DW +: DW] == pat(3, 6), f_regs[3*DW +: DW], pat(3, 6));

    // R9 unmapped and read-only
    xfer(0, 8'h80, 0, rd, e, c); chk("R9 unmapped", rd == 0 && e == 0, rd, 0);
    xfer(1, 8'h00, 0, rd, e, c);
    xfer(0, 8'h00, 0, rd, e, c); chk("R9 id kept", rd == 32'h5157_0001, rd, 32'h5157_0001);
    xfer(1, 8'h04, 0, rd, e, c);
    xfer(0, 8'h04, 0, rd, e, c); chk("R9 sysstat kept", rd == 1, rd, 1);
    xfer(1, 8'h0C, 32'h1F, rd, e, c);
    xfer(0, 8'h0C, 0, rd, e, c); chk("R9 pending kept", rd == 0, rd, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule